// File: doc/BRIEF.md
# Ramped Six-Channel Digital Volume Attenuator

This block attenuates six signed audio sample streams, each by its own 8-bit code. Every step of the code is 0.5 dB of attenuation. A code of 181 gives 90.5 dB. Any code above 181 silences the channel.

A new code written to a channel does not take effect at once. The block holds the written code as a target and moves an applied code toward it one step at a time. The ramp-rate input sets how often a step happens, measured in frame strobes. This stepping avoids audible zipper noise.

On each frame strobe, every channel converts its applied code into a linear gain. The gain is the product of two parts:
- a twelve-entry fractional gain that covers one 6 dB octave;
- a binary right shift of one bit per twelve codes.

The block multiplies the sample by this gain, rounds the product and saturates it, then registers the result as the channel output. The applied codes are also outputs, so a system can watch a ramp as it progresses.

Top module: `vol_ramp_atten`

## Requirements
- R1: After reset, every target code, every applied code and every output sample is 0.
- R2: A cycle with `wr_en` high and `wr_addr` from 0 to 5 stores `wr_data` as the target of that channel. Writes to addresses 6 and 7 change no channel.
- R3: On each step, the applied code moves by exactly one toward the effective target, never past it. When the applied code equals the effective target, it stays.
- R4: The block counts frame strobes since reset modulo 8, taking the count before each strobe's increment. A step occurs only on a strobe whose count is a multiple of 1, 2, 4 or 8, for `ramp_rate` 0, 1, 2 or 3. Between strobes the applied codes hold.
- R5: A target above 181 acts as 182. The applied code ramps to 182 and stays there, and at 182 the channel output is 0.
- R6: For an applied code c of 181 or less, the output is floor(s*G/2^(15+c/12) + 0.5), saturated to the signed sample width. Here s is the input sample, G = round(32768*10^(-(c mod 12)/40)), and c/12 uses integer division.
- R7: The output register of a channel loads only on a frame strobe. It uses the applied code as it stood before that strobe's step, and it holds between strobes.
- R8: A write during a ramp retargets it. The ramp continues from the current applied code, without returning to 0 and without a jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse per audio frame |
| ramp_rate | input | 2 | Frames per step: 0→1, 1→2, 2→4, 3→8 |
| wr_en | input | 1 | Target write strobe |
| wr_addr | input | 3 | Channel index 0..5 of the write |
| wr_data | input | 8 | Target attenuation code |
| samples_in | input | 144 | Six signed 24-bit samples; channel n occupies bits [24n+23:24n] |
| samples_out | output | 144 | Six attenuated signed 24-bit samples, same packing |
| applied_codes | output | 48 | Six applied codes; channel n occupies bits [8n+7:8n] |

## Verification
The following properties are checked on every cycle:
- each applied code moves by at most one step per cycle, never passes its effective target, never exceeds 182, and changes only on a frame strobe;
- the frame counter advances exactly once per strobe;
- the output registers hold between strobes;
- a channel at the mute level produces zero.

Only the bench scenarios can show the following:
- the exact step cadence at each rate setting;
- retargeting in mid-ramp;
- address decoding that ignores 6 and 7;
- the numeric gain, rounding and saturation at codes such as 0, 181 and full-scale negative input. The bench computes these from the decibel formula with real arithmetic.

// File: rtl/vra_pkg.sv
package vra_pkg;
  localparam int GAIN_W    = 16;  // unsigned gain, 1.0 == 2**GAIN_FRAC
  localparam int GAIN_FRAC = 15;
  localparam int STEPS_6DB = 12;  // codes per octave of attenuation
  localparam int MUTE_CODE = 182; // first code treated as silence
  localparam int RATE_W    = 2;

  // Fractional gain for k half-decibel steps inside one 6 dB octave.
  function automatic logic [GAIN_W-1:0] gain_lut(input logic [3:0] k);
    case (k)
      4'd0:    return 16'd32768;
      4'd1:    return 16'd30935;
      4'd2:    return 16'd29205;
      4'd3:    return 16'd27571;
      4'd4:    return 16'd26029;
      4'd5:    return 16'd24573;
      4'd6:    return 16'd23198;
      4'd7:    return 16'd21900;
      4'd8:    return 16'd20675;
      4'd9:    return 16'd19519;
      4'd10:   return 16'd18427;
      4'd11:   return 16'd17396;
      default: return 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/vol_frame_tick.sv
module vol_frame_tick
  import vra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame,
  input  logic [RATE_W-1:0] rate,
  output logic              step_ev
);
  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] fcnt_q;
  logic [CNT_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(rate));
  end

  assign step_ev = ((fcnt_q & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     fcnt_q <= '0;
    else if (frame) fcnt_q <= fcnt_q + 1'b1;
  end

  assert_cnt_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame |=> fcnt_q == $past(fcnt_q) + 1'b1);
  assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame |=> $stable(fcnt_q));
endmodule

// File: rtl/vol_ramp.sv
module vol_ramp
  import vra_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          frame,
  input  logic          step_ev,
  output logic [CW-1:0] applied
);
  localparam logic [CW-1:0] MUTE = CW'(MUTE_CODE);

  logic [CW-1:0] tgt_q, cur_q, tgt_eff;
  logic          go_up, go_dn, do_step;

  assign tgt_eff = (tgt_q > MUTE) ? MUTE : tgt_q;
  assign go_up   = cur_q < tgt_eff;
  assign go_dn   = cur_q > tgt_eff;
  assign do_step = frame && step_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= '0;
      cur_q <= '0;
    end else begin
      if (wr_sel) tgt_q <= wr_data;
      if (do_step && go_up)      cur_q <= cur_q + 1'b1;
      else if (do_step && go_dn) cur_q <= cur_q - 1'b1;
    end
  end

  assign applied = cur_q;

  assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cur_q == $past(cur_q)) || (cur_q == $past(cur_q) + 1'b1) ||
             (cur_q + 1'b1 == $past(cur_q)));
  assert_no_overshoot_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q < tgt_eff) |=> cur_q <= $past(tgt_eff));
  assert_no_overshoot_dn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q > tgt_eff) |=> cur_q >= $past(tgt_eff));
  assert_hold_between_frames_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame |=> $stable(cur_q));
  assert_mute_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q <= MUTE);
endmodule

// File: rtl/vol_gain.sv
module vol_gain
  import vra_pkg::*;
#(
  parameter int SW = 24,
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame,
  input  logic signed [SW-1:0] sample_in,
  input  logic        [CW-1:0] code,
  output logic signed [SW-1:0] sample_out
);
  localparam int PW = SW + GAIN_W + 1;
  localparam logic signed [PW-1:0] SMAX = {{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [PW-1:0] SMIN = {{(PW-SW+1){1'b1}}, {(SW-1){1'b0}}};

  // Multiply by the octave-fraction gain, then round-half-up shift and clamp.
  function automatic logic signed [SW-1:0] scale(input logic signed [SW-1:0] s,
                                                 input logic [CW-1:0] c);
    logic [3:0]            frac;
    logic [5:0]            sh;
    logic signed [PW-1:0]  prod, half, rnd;
    frac = 4'(c % CW'(STEPS_6DB));
    sh   = 6'(GAIN_FRAC) + 6'(c / CW'(STEPS_6DB));
    prod = PW'(s) * $signed({1'b0, gain_lut(frac)});
    half = PW'(1) <<< (sh - 6'd1);
    rnd  = (prod + half) >>> sh;
    if (rnd > SMAX)      return SW'(SMAX);
    else if (rnd < SMIN) return SW'(SMIN);
    else                 return SW'(rnd);
  endfunction

  logic mute_w;
  assign mute_w = code >= CW'(MUTE_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n)     sample_out <= '0;
    else if (frame) sample_out <= mute_w ? '0 : scale(sample_in, code);
  end

  assert_mute_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && mute_w) |=> sample_out == '0);
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame |=> $stable(sample_out));
endmodule

// File: rtl/vol_ramp_atten.sv
module vol_ramp_atten
  import vra_pkg::*;
#(
  parameter int NCH = 6,
  parameter int SW  = 24,
  parameter int CW  = 8,
  parameter int AW  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_stb,
  input  logic [RATE_W-1:0]     ramp_rate,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [CW-1:0]         wr_data,
  input  logic [NCH*SW-1:0]     samples_in,
  output logic [NCH*SW-1:0]     samples_out,
  output logic [NCH*CW-1:0]     applied_codes
);
  logic step_ev;

  vol_frame_tick u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame   (frame_stb),
    .rate    (ramp_rate),
    .step_ev (step_ev)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic                 wr_sel;
    logic        [CW-1:0] code_w;
    logic signed [SW-1:0] out_w;

    assign wr_sel = wr_en && (wr_addr == AW'(ch));

    vol_ramp #(.CW(CW)) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .frame   (frame_stb),
      .step_ev (step_ev),
      .applied (code_w)
    );

    vol_gain #(.SW(SW), .CW(CW)) u_gain (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame      (frame_stb),
      .sample_in  ($signed(samples_in[ch*SW +: SW])),
      .code       (code_w),
      .sample_out (out_w)
    );

    assign samples_out[ch*SW +: SW]   = out_w;
    assign applied_codes[ch*CW +: CW] = code_w;
  end
endmodule

// File: tb/vol_ramp_atten_tb.sv
`timescale 1ns/1ps
module vol_ramp_atten_tb_top;
  localparam int NCH = 6;
  localparam int SW  = 24;
  localparam int CW  = 8;
  localparam int NV  = 13;
  // row: write address (-1 = none), write data, ramp rate, expected channel-0 code after the frame
  localparam int VEC [NV][4] = '{
    '{0, 4, 0, 1}, '{5, 2, 0, 2}, '{-1, 0, 0, 3}, '{-1, 0, 0, 4}, '{-1, 0, 0, 4},
    '{0, 0, 1, 4}, '{-1, 0, 1, 3}, '{-1, 0, 1, 3}, '{-1, 0, 1, 2},
    '{0, 6, 1, 2}, '{-1, 0, 1, 3}, '{-1, 0, 2, 3}, '{-1, 0, 2, 4}};

  logic              clk = 0, rst_n = 0, frame_stb = 0, wr_en = 0;
  logic [1:0]        ramp_rate = 0;
  logic [2:0]        wr_addr = 0;
  logic [CW-1:0]     wr_data = 0;
  logic [NCH*SW-1:0] samples_in = 0;
  logic [NCH*SW-1:0] samples_out;
  logic [NCH*CW-1:0] applied_codes;

  int n_chk = 0, n_bad = 0, fidx = 0;
  int m_tgt[NCH], m_cur[NCH], m_fcnt;
  int s_drv[NCH];
  bit done = 0;

  always #2.5 clk = ~clk;

  vol_ramp_atten dut_i (.*);

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int exp_scale(int s, int c);
    real g, x;
    int  r;
    if (c >= 182) return 0;
    g = $floor(32768.0 * $pow(10.0, -real'(c % 12) / 40.0) + 0.5);
    x = real'(s) * g / $pow(2.0, real'(15 + c / 12));
    r = $rtoi($floor(x + 0.5));
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return r;
  endfunction

  function automatic int out_of(int c);
    return int'($signed(samples_out[c*SW +: SW]));
  endfunction

  function automatic int code_of(int c);
    return int'(applied_codes[c*CW +: CW]);
  endfunction

  task automatic set_sample(int c, int s);
    s_drv[c] = s;
    samples_in[c*SW +: SW] = SW'(s);
  endtask

  task automatic do_write(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
    if (a < NCH) m_tgt[a] = d;
  endtask

  // One frame: predict from pre-step codes, step the model, check after the edge.
  task automatic do_frame(string req);
    int e_out[NCH];
    int eff;
    for (int c = 0; c < NCH; c++) e_out[c] = exp_scale(s_drv[c], m_cur[c]);
    if ((m_fcnt % (1 << ramp_rate)) == 0)
      for (int c = 0; c < NCH; c++) begin
        eff = (m_tgt[c] > 182) ? 182 : m_tgt[c];
        if (m_cur[c] < eff) m_cur[c]++;
        else if (m_cur[c] > eff) m_cur[c]--;
      end
    m_fcnt = (m_fcnt + 1) % 8;
    fidx++;
    @(negedge clk);
    frame_stb = 1;
    @(negedge clk);
    frame_stb = 0;
    for (int c = 0; c < NCH; c++) begin
      chk({req, " R6 out"}, out_of(c), e_out[c]);
      chk({req, " R3 code"}, code_of(c), m_cur[c]);
    end
  endtask

  task automatic pattern_samples();
    for (int c = 0; c < NCH; c++)
      set_sample(c, ((fidx * 7919 + c * 104729) % 16777216) - 8388608);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int prev[NCH];
    for (int c = 0; c < NCH; c++) begin m_tgt[c] = 0; m_cur[c] = 0; s_drv[c] = 0; end
    m_fcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state at the ports
    for (int c = 0; c < NCH; c++) begin
      chk("R1 code", code_of(c), 0);
      chk("R1 out", out_of(c), 0);
    end

    // Table walk: R2 R3 R4 R6 R7 R8 (row 9 retargets mid-ramp, R8)
    for (int v = 0; v < NV; v++) begin
      ramp_rate = 2'(VEC[v][2]);
      if (VEC[v][0] >= 0) do_write(VEC[v][0], VEC[v][1]);
      pattern_samples();
      do_frame("R4 table");
      chk("R8 R4 table ch0 code", code_of(0), VEC[v][3]);
    end

    // R2: addresses 6 and 7 touch no channel
    ramp_rate = 0;
    do_write(6, 99);
    do_write(7, 150);
    pattern_samples();
    do_frame("R2 ignored");
    for (int c = 1; c < NCH - 1; c++) chk("R2 ignored addr code", code_of(c), 0);

    // R7: outputs hold when samples change without a strobe
    for (int c = 0; c < NCH; c++) prev[c] = out_of(c);
    for (int c = 0; c < NCH; c++) set_sample(c, 1234 - c * 777);
    repeat (4) @(negedge clk);
    for (int c = 0; c < NCH; c++) chk("R7 hold", out_of(c), prev[c]);

    // R6 extremes at code 0 on channel 2 (target 0)
    set_sample(2, -8388608);
    do_frame("R6 negfull");
    set_sample(2, 8388607);
    do_frame("R6 posfull");

    // R5: over-range target ramps to 182 and mutes; 181 keeps a nonzero gain
    do_write(1, 255);
    do_write(3, 181);
    do_write(4, 200);
    for (int f = 0; f < 190; f++) begin
      pattern_samples();
      set_sample(1, 8388607);
      set_sample(3, 8388607);
      do_frame("R5 ramp");
    end
    chk("R5 mute code", code_of(1), 182);
    chk("R5 mute code ch4", code_of(4), 182);
    chk("R6 code 181", code_of(3), 181);
    do_frame("R5 mute frame");
    chk("R5 muted output", out_of(1), 0);
    chk("R6 code-181 output", out_of(3), exp_scale(8388607, 181));

    // R8: retarget downward from the mute level continues from 182
    do_write(1, 170);
    do_frame("R8 retarget");
    chk("R8 retarget code", code_of(1), 181);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule